// File: doc/BRIEF.md
# Command/Indicate Channel Change Validator

This block sits behind a frame deserializer on a signalling channel. In every frame it receives one channel byte, qualified by a single-cycle frame strobe. The upper six bits of the byte form a command/indicate (C/I) code, and the two low bits carry monitor handshake bits. A new C/I code is accepted only after it has arrived in two frames in a row. This filters single-frame glitches out of the control path that drives hook, ring and tone logic.

Two registers hold the state. The accepted register keeps the current C/I state. The candidate register keeps a code that has been seen once and is waiting for confirmation, together with a flag that marks the candidate as valid. When a candidate is confirmed, it is copied into the accepted register and a one-clock change pulse is raised. Four control flags are decoded from the accepted code. The two monitor bits bypass validation: they are captured from each strobed byte and driven straight out.

Top module: `ci_change_validator`

## Requirements
- R1: While reset is held, and after reset until the first strobe, the accepted code reads 0, no candidate is pending, the change pulse is low and both monitor outputs are 0.
- R2: The C/I code is taken from chan_byte bits 7..2, with bit 7 the most significant code bit. The first monitor bit (mon_mr) is bit 1 and the second (mon_mx) is bit 0.
- R3: A strobed code equal to the accepted code never changes the accepted code and never raises the change pulse.
- R4: A code that differs from the accepted code becomes the accepted code when the next strobed frame carries the same code. The accepted output changes at the clock edge that samples that second strobe.
- R5: The change pulse is high for exactly one clock, in the cycle after the committing strobe, and at no other time.
- R6: A pending candidate is replaced when the next frame carries a code that differs from both the candidate and the accepted code. Only a repeat of the newest candidate commits.
- R7: A frame that carries the accepted code while a candidate is pending discards the candidate. A later single frame of the old candidate therefore does not commit.
- R8: State changes only on cycles with frame_stb high. chan_byte is ignored on all other cycles.
- R9: The flags follow the accepted code: flag_offhook = code bit 0, flag_ring = code bit 1, flag_tone_en = code bit 2, flag_onhook_mon = code bit 3. Code bits 5 and 4 are reserved and drive no flag.
- R10: mon_mr and mon_mx show the monitor bits of the most recent strobed byte, whatever the validation outcome of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe marking a valid channel byte |
| chan_byte | input | 8 | Channel byte: C/I code in bits 7..2, monitor bits in 1..0 |
| ci_accepted | output | 6 | Accepted C/I code |
| flag_onhook_mon | output | 1 | On-hook monitor enable (code bit 3) |
| flag_tone_en | output | 1 | Tone/gain enable (code bit 2) |
| flag_ring | output | 1 | Ring indication (code bit 1) |
| flag_offhook | output | 1 | Off-hook indication (code bit 0) |
| ci_changed | output | 1 | One-clock pulse after a commit |
| mon_mr | output | 1 | Monitor bit from chan_byte bit 1 |
| mon_mx | output | 1 | Monitor bit from chan_byte bit 0 |

## Verification
Several properties are checked on every cycle. The accepted code moves only after a strobe and always together with the change pulse. The pulse never lasts two cycles. A strobe that repeats the accepted code never pulses. The monitor bits follow each strobed byte and hold between strobes. Other behaviour depends on candidate history that no single-cycle property can see: replacement of a candidate, cancellation by a return to the accepted code, the need for a fresh repeat after a cancel, and the flag mapping across many codes. The scoreboard scenarios cover these using a reference model of the two registers built from the requirements.

// File: rtl/civ_pkg.sv
package civ_pkg;

    // Default widths of the channel byte fields
    localparam int unsigned CI_W_DEF = 6;
    localparam int unsigned MON_W    = 2;

    // Decoded control flags taken from the low code bits
    localparam int unsigned FLAG_N = 4;
    // flag index -> code bit: 0 off-hook, 1 ring, 2 tone enable, 3 on-hook monitor
    localparam int unsigned FLAG_POS [FLAG_N] = '{0, 1, 2, 3};

    // Outcome of one strobed frame
    typedef enum logic [2:0] {
        DEC_IDLE,    // no strobe this cycle
        DEC_HOLD,    // code equals accepted, nothing pending
        DEC_CANCEL,  // code equals accepted, pending candidate dropped
        DEC_COMMIT,  // code repeats candidate, candidate becomes accepted
        DEC_STAGE    // code differs from both, becomes the candidate
    } civ_dec_e;

endpackage

// File: rtl/civ_field_split.sv
module civ_field_split #(
    parameter int unsigned CI_W  = 6,
    parameter int unsigned MON_W = 2,
    localparam int unsigned BYTE_W = CI_W + MON_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CI_W-1:0]   ci_o,
    output logic [MON_W-1:0]  mon_o
);

    // Code occupies the upper field, monitor bits the lower field
    assign ci_o  = byte_i[BYTE_W-1:MON_W];
    assign mon_o = byte_i[MON_W-1:0];

endmodule

// File: rtl/civ_commit_core.sv
module civ_commit_core
    import civ_pkg::*;
#(
    parameter int unsigned CI_W  = 6,
    parameter int unsigned MON_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [CI_W-1:0]  ci_i,
    input  logic [MON_W-1:0] mon_i,
    output logic [CI_W-1:0]  acc_o,
    output logic             chg_o,
    output logic [MON_W-1:0] mon_o
);

    typedef struct packed {
        logic [CI_W-1:0]  prim;   // accepted code
        logic [CI_W-1:0]  cand;   // candidate awaiting confirmation
        logic             pend;   // candidate valid
        logic             chg;    // commit pulse
        logic [MON_W-1:0] mon;    // monitor bits, unvalidated
    } civ_state_t;

    civ_state_t st_d, st_q;
    civ_dec_e   dec;

    // Classify the current frame against both registers
    always_comb begin
        dec = DEC_IDLE;
        if (stb_i) begin
            if (ci_i == st_q.prim) begin
                dec = st_q.pend ? DEC_CANCEL : DEC_HOLD;
            end else if (st_q.pend && (ci_i == st_q.cand)) begin
                dec = DEC_COMMIT;
            end else begin
                dec = DEC_STAGE;
            end
        end
    end

    // Next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (stb_i) begin
            st_d.mon = mon_i;
        end
        case (dec)
            DEC_HOLD,
            DEC_CANCEL: begin
                st_d.pend = 1'b0;
            end
            DEC_COMMIT: begin
                st_d.prim = st_q.cand;
                st_d.pend = 1'b0;
                st_d.chg  = 1'b1;
            end
            DEC_STAGE: begin
                st_d.cand = ci_i;
                st_d.pend = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.prim;
    assign chg_o = st_q.chg;
    assign mon_o = st_q.mon;

endmodule

// File: rtl/civ_flag_decode.sv
module civ_flag_decode
    import civ_pkg::*;
(
    input  logic [FLAG_N-1:0] low_code_i,
    output logic [FLAG_N-1:0] flags_o
);

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
        assign flags_o[gi] = low_code_i[FLAG_POS[gi]];
    end

endmodule

// File: rtl/ci_change_validator.sv
module ci_change_validator
    import civ_pkg::*;
#(
    parameter int unsigned CI_W = CI_W_DEF,
    localparam int unsigned BYTE_W = CI_W + MON_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [BYTE_W-1:0] chan_byte,
    output logic [CI_W-1:0]   ci_accepted,
    output logic              flag_onhook_mon,
    output logic              flag_tone_en,
    output logic              flag_ring,
    output logic              flag_offhook,
    output logic              ci_changed,
    output logic              mon_mr,
    output logic              mon_mx
);

    logic [CI_W-1:0]   rx_ci;
    logic [MON_W-1:0]  rx_mon;
    logic [MON_W-1:0]  mon_q;
    logic [FLAG_N-1:0] flags;

    civ_field_split #(
        .CI_W  (CI_W),
        .MON_W (MON_W)
    ) split_i (
        .byte_i (chan_byte),
        .ci_o   (rx_ci),
        .mon_o  (rx_mon)
    );

    civ_commit_core #(
        .CI_W  (CI_W),
        .MON_W (MON_W)
    ) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (frame_stb),
        .ci_i  (rx_ci),
        .mon_i (rx_mon),
        .acc_o (ci_accepted),
        .chg_o (ci_changed),
        .mon_o (mon_q)
    );

    civ_flag_decode flags_i (
        .low_code_i (ci_accepted[FLAG_N-1:0]),
        .flags_o    (flags)
    );

    assign flag_offhook    = flags[0];
    assign flag_ring       = flags[1];
    assign flag_tone_en    = flags[2];
    assign flag_onhook_mon = flags[3];
    assign mon_mr          = mon_q[1];
    assign mon_mx          = mon_q[0];

endmodule

// File: rtl/civ_checker.sv
module civ_checker
    import civ_pkg::*;
#(
    parameter int unsigned CI_W = CI_W_DEF,
    localparam int unsigned BYTE_W = CI_W + MON_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic [BYTE_W-1:0] chan_byte,
    input logic [CI_W-1:0]   ci_accepted,
    input logic              ci_changed,
    input logic              mon_mr,
    input logic              mon_mx
);

    // R3: repeating the accepted code never pulses
    assert_same_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && chan_byte[BYTE_W-1:MON_W] == ci_accepted) |=> !ci_changed);

    // R4: every move of the accepted code comes with the change pulse
    assert_move_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_accepted) |-> ci_changed);

    // R5: pulse is one clock wide
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ci_changed |=> !ci_changed);

    // R5: pulse only follows a strobe
    assert_pulse_after_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ci_changed |-> $past(frame_stb));

    // R8: accepted code moves only after a strobe
    assert_move_needs_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_accepted) |-> $past(frame_stb));

    // R8: monitor bits hold between strobes
    assert_mon_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(mon_mr) && $stable(mon_mx)));

    // R10: monitor bits follow the strobed byte
    assert_mon_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> ({mon_mr, mon_mx} == $past(chan_byte[MON_W-1:0])));

endmodule

bind ci_change_validator civ_checker #(.CI_W(CI_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb   (frame_stb),
    .chan_byte   (chan_byte),
    .ci_accepted (ci_accepted),
    .ci_changed  (ci_changed),
    .mon_mr      (mon_mr),
    .mon_mx      (mon_mx)
);

// File: tb/ci_change_validator_tb_top.sv
`timescale 1ns/1ps
module ci_change_validator_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [7:0] chan_byte = 8'h00;
    logic [5:0] ci_accepted;
    logic       flag_onhook_mon, flag_tone_en, flag_ring, flag_offhook;
    logic       ci_changed, mon_mr, mon_mx;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ci_change_validator dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_stb       (frame_stb),
        .chan_byte       (chan_byte),
        .ci_accepted     (ci_accepted),
        .flag_onhook_mon (flag_onhook_mon),
        .flag_tone_en    (flag_tone_en),
        .flag_ring       (flag_ring),
        .flag_offhook    (flag_offhook),
        .ci_changed      (ci_changed),
        .mon_mr          (mon_mr),
        .mon_mx          (mon_mx)
    );

    typedef struct {
        logic [5:0] acc;
        logic       chg;
        logic [1:0] mon;
        string      tag;
    } exp_t;

    exp_t q[$];

    // Reference model of accepted/candidate registers
    logic [5:0] m_p = '0;
    logic [5:0] m_s = '0;
    logic       m_pv = 1'b0;
    logic [1:0] m_mon = '0;

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input exp_t e);
        cmp(e.tag, "ci_accepted", {2'b00, ci_accepted}, {2'b00, e.acc});
        cmp(e.tag, "ci_changed", {7'd0, ci_changed}, {7'd0, e.chg});
        cmp(e.tag, "mon", {6'd0, mon_mr, mon_mx}, {6'd0, e.mon});
        // R9 flag mapping from the expected accepted code
        cmp({e.tag, "/R9"}, "flags",
            {4'd0, flag_onhook_mon, flag_tone_en, flag_ring, flag_offhook},
            {4'd0, e.acc[3], e.acc[2], e.acc[1], e.acc[0]});
    endtask

    // Monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp_all(e);
        end
    end

    // Driver: one strobed frame, expected result pushed after the edge
    task automatic send_frame(input logic [5:0] ci, input logic [1:0] mon,
                              input string tag);
        exp_t e;
        logic chg;
        @(negedge clk);
        chan_byte = {ci, mon};   // R2 field positions
        frame_stb = 1'b1;
        chg = 1'b0;
        m_mon = mon;
        if (ci == m_p) begin
            m_pv = 1'b0;
        end else if (m_pv && ci == m_s) begin
            m_p = m_s;
            m_pv = 1'b0;
            chg = 1'b1;
        end else begin
            m_s = ci;
            m_pv = 1'b1;
        end
        @(posedge clk);
        #1;
        e.acc = m_p; e.chg = chg; e.mon = m_mon; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    // Idle cycle: nothing may change and the pulse must be low
    task automatic idle_check(input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.acc = m_p; e.chg = 1'b0; e.mon = m_mon; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        chan_byte = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        cmp("R1", "ci_accepted", {2'b00, ci_accepted}, 8'h00);
        cmp("R1", "ci_changed", {7'd0, ci_changed}, 8'h00);
        cmp("R1", "mon", {6'd0, mon_mr, mon_mx}, 8'h00);
        rst_n = 1'b1;
        idle_check("R1_after_release");

        // R3: accepted value repeated
        send_frame(6'h00, 2'b01, "R3_equal");
        send_frame(6'h00, 2'b10, "R3_equal_again");

        // R4/R5: two-frame commit of 0x21
        send_frame(6'h21, 2'b10, "R4_first_frame");
        send_frame(6'h21, 2'b11, "R4_commit");
        idle_check("R5_pulse_gone");
        send_frame(6'h21, 2'b00, "R3_after_commit");

        // R6: candidate replaced, newest repeat commits
        send_frame(6'h05, 2'b01, "R6_cand_a");
        send_frame(6'h0A, 2'b10, "R6_cand_b");
        send_frame(6'h05, 2'b00, "R6_old_no_commit");
        send_frame(6'h05, 2'b11, "R6_commit_a");
        idle_check("R5_idle");

        // R7: return to accepted cancels candidate
        send_frame(6'h3C, 2'b01, "R7_cand");
        send_frame(6'h05, 2'b10, "R7_cancel");
        send_frame(6'h3C, 2'b11, "R7_single_no_commit");
        send_frame(6'h3C, 2'b00, "R7_then_commit");

        // R8: byte changes without strobe are ignored
        send_frame(6'h0F, 2'b01, "R8_cand");
        @(negedge clk);
        chan_byte = {6'h0F, 2'b10};
        idle_check("R8_no_stb_1");
        idle_check("R8_no_stb_2");
        chan_byte = {6'h12, 2'b11};
        idle_check("R8_no_stb_3");
        send_frame(6'h0F, 2'b01, "R8_commit_by_stb");

        // R9: walk flag patterns through commits
        send_frame(6'h08, 2'b00, "R9_on");
        send_frame(6'h08, 2'b00, "R9_onhook");
        send_frame(6'h34, 2'b00, "R9_t");
        send_frame(6'h34, 2'b00, "R9_tone");
        send_frame(6'h2A, 2'b00, "R9_r");
        send_frame(6'h2A, 2'b00, "R9_ring");
        send_frame(6'h30, 2'b00, "R9_rsv");
        send_frame(6'h30, 2'b00, "R9_reserved_only");

        // R10: monitor bits follow every frame regardless of outcome
        send_frame(6'h11, 2'b10, "R10_stage");
        send_frame(6'h30, 2'b01, "R10_cancel");
        send_frame(6'h30, 2'b11, "R10_hold");

        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule